// File: doc/BRIEF.md
# Output Virtual Channel Allocator

This block hands out downstream virtual channels to packets waiting at the inputs of a network router. Every input virtual channel whose head flit has finished route computation raises a request and names the output port it needs. The allocator tracks a busy flag for every virtual channel of every output port. Each cycle, every output port that still has a free channel picks one requester by round-robin order and hands it the lowest-numbered free channel of that port. The requester receives the channel index one cycle after it asked.

A channel belongs to the winning packet for the packet's whole lifetime. Only the head flit asks for it, and the body and tail flits of the packet travel on the same channel without asking again. When the tail flit leaves on that output, the switch side pulses a release for the (port, channel) pair, and the channel can be granted again on the following cycle. A packet that does not yet hold a channel cannot enter switch allocation, so the grant here gates that later stage.

Requesters are numbered `r = input_port * IN_VCS + input_vc`. Requesters that lose keep their request raised and compete again on the next cycle.

Top module: `ovc_alloc`

## Requirements
- R1: After reset, every output channel is free, every port's round-robin pointer sits at requester 0, and no grant is asserted.
- R2: A grant to requester r is asserted only in the cycle right after a cycle in which r requested a valid port, and it lasts one cycle.
- R3: Each output port grants at most one requester per cycle, and only while it has a free channel. The granted channel is the lowest-numbered free channel of that port. Different ports grant independently in the same cycle.
- R4: The winner on a port is the first eligible requester at or after that port's pointer, counting upward with wrap from N_REQ-1 to 0. On a grant the pointer moves to winner+1 (mod N_REQ). Without a grant it stays where it is.
- R5: A granted channel is busy from the cycle its grant is visible, and it is not granted again until it is released.
- R6: A release of (port p, channel v) sampled at the edge that ends cycle N makes v grantable in cycle N+1, so its grant is visible in cycle N+2. A release of a channel that is already free has no effect, and a grant always takes priority over a release of the same channel.
- R7: A requester that loses and keeps its request raised is granted in a later cycle without any other action.
- R8: A requester whose grant is visible in the current cycle is not eligible in that cycle. A request held for one cycle after its grant therefore takes no second channel.
- R9: A request that names a port number greater than or equal to NUM_PORTS is never granted and uses no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_REQ | Per requester: head flit waiting for an output channel |
| req_port | input | N_REQ x PORT_W | Per requester: output port from route computation |
| rel_valid | input | NUM_PORTS | Per output port: tail flit left, so free a channel |
| rel_vc | input | NUM_PORTS x VC_W | Per output port: channel index being freed |
| gnt_valid | output | N_REQ | Per requester: registered grant, one-cycle pulse |
| gnt_vc | output | N_REQ x VC_W | Per requester: granted output channel index |

## Verification
The hardest state to reach from the ports is an output port with every channel busy and a requester still waiting. In that state the exact cycle at which a release lets the waiting requester through must be observed, along with the fact that nothing else moves before then. The stimulus fills one port with a sequence of requests whose round-robin order wraps past the last requester. It leaves one more request waiting, pulses a single release, and checks that the grant appears two cycles later and not one. A request held one cycle past its own grant is followed by a fresh request on the same port, which shows whether a second channel was taken. Random traffic with packet lengths of several cycles, compared every clock against a behavioural model, then exercises contention across all ports together.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

   // Index width for a count of n items (at least one bit)
   function automatic int idx_bits(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ovc_rr_arb.sv
module ovc_rr_arb
   import ovc_pkg::*;
#(
   parameter int N = 4,
   localparam int IDX_W = idx_bits(N)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             en,
   output logic             win_valid,
   output logic [IDX_W-1:0] win_idx
);

   if (N < 1) begin : g_bad_n
      $error("ovc_rr_arb: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign win_valid = en & req[0];
      assign win_idx   = '0;
   end else begin : g_rotate
      logic [IDX_W-1:0] ptr_q;
      logic [IDX_W:0]   cand;
      logic             found;

      always_comb begin
         found   = 1'b0;
         win_idx = '0;
         cand    = '0;
         for (int i = 0; i < N; i++) begin
            cand = {1'b0, ptr_q} + (IDX_W+1)'(i);
            if (cand >= (IDX_W+1)'(N)) begin
               cand = cand - (IDX_W+1)'(N);
            end
            if (!found && req[cand[IDX_W-1:0]]) begin
               found   = 1'b1;
               win_idx = cand[IDX_W-1:0];
            end
         end
         win_valid = found & en;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (win_valid) begin
            if (win_idx == IDX_W'(N-1)) begin
               ptr_q <= '0;
            end else begin
               ptr_q <= win_idx + IDX_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/ovc_free_pool.sv
module ovc_free_pool
   import ovc_pkg::*;
#(
   parameter int NV = 4,
   localparam int VC_W = idx_bits(NV)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc,
   input  logic            rel_valid,
   input  logic [VC_W-1:0] rel_vc,
   output logic            free_any,
   output logic [VC_W-1:0] free_idx
);

   if (NV < 1) begin : g_bad_nv
      $error("ovc_free_pool: NV must be at least 1");
   end

   logic [NV-1:0] busy_q;

   // Lowest-numbered free channel wins
   always_comb begin
      free_any = ~&busy_q;
      free_idx = '0;
      for (int v = NV - 1; v >= 0; v--) begin
         if (!busy_q[v]) begin
            free_idx = VC_W'(v);
         end
      end
   end

   // Release is written first so a grant to the same channel wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         if (rel_valid && (int'(rel_vc) < NV)) begin
            busy_q[rel_vc] <= 1'b0;
         end
         if (alloc && free_any) begin
            busy_q[free_idx] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ovc_alloc.sv
module ovc_alloc
   import ovc_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int IN_VCS    = 4,
   parameter int OUT_VCS   = 4,
   localparam int N_REQ  = NUM_PORTS * IN_VCS,
   localparam int PORT_W = idx_bits(NUM_PORTS),
   localparam int VC_W   = idx_bits(OUT_VCS),
   localparam int REQ_W  = idx_bits(N_REQ)
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_REQ-1:0]                  req_valid,
   input  logic [N_REQ-1:0][PORT_W-1:0]      req_port,
   input  logic [NUM_PORTS-1:0]              rel_valid,
   input  logic [NUM_PORTS-1:0][VC_W-1:0]    rel_vc,
   output logic [N_REQ-1:0]                  gnt_valid,
   output logic [N_REQ-1:0][VC_W-1:0]        gnt_vc
);

   if (NUM_PORTS < 1 || IN_VCS < 1 || OUT_VCS < 1) begin : g_bad_cfg
      $error("ovc_alloc: port and channel counts must be at least 1");
   end

   logic [NUM_PORTS-1:0][N_REQ-1:0]  elig;
   logic [NUM_PORTS-1:0]             win_valid;
   logic [NUM_PORTS-1:0][REQ_W-1:0]  win_idx;
   logic [NUM_PORTS-1:0]             free_any;
   logic [NUM_PORTS-1:0][VC_W-1:0]   free_idx;
   logic [N_REQ-1:0]                 gnt_valid_d;
   logic [N_REQ-1:0][VC_W-1:0]       gnt_vc_d;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      // A requester whose grant is on the outputs now sits this cycle out
      for (genvar r = 0; r < N_REQ; r++) begin : g_elig
         assign elig[p][r] = req_valid[r] && !gnt_valid[r] &&
                             (req_port[r] == PORT_W'(p));
      end

      ovc_rr_arb #(.N(N_REQ)) u_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (elig[p]),
         .en        (free_any[p]),
         .win_valid (win_valid[p]),
         .win_idx   (win_idx[p])
      );

      ovc_free_pool #(.NV(OUT_VCS)) u_pool (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (win_valid[p]),
         .rel_valid (rel_valid[p]),
         .rel_vc    (rel_vc[p]),
         .free_any  (free_any[p]),
         .free_idx  (free_idx[p])
      );
   end

   // Route each port's winner back to its requester slot
   always_comb begin
      gnt_valid_d = '0;
      gnt_vc_d    = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (win_valid[p]) begin
            gnt_valid_d[win_idx[p]] = 1'b1;
            gnt_vc_d[win_idx[p]]    = free_idx[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_valid <= '0;
         gnt_vc    <= '0;
      end else begin
         gnt_valid <= gnt_valid_d;
         gnt_vc    <= gnt_vc_d;
      end
   end

endmodule

// File: rtl/ovc_alloc_chk.sv
module ovc_alloc_chk
   import ovc_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int IN_VCS    = 4,
   parameter int OUT_VCS   = 4,
   localparam int N_REQ  = NUM_PORTS * IN_VCS,
   localparam int PORT_W = idx_bits(NUM_PORTS),
   localparam int VC_W   = idx_bits(OUT_VCS)
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic [N_REQ-1:0]              req_valid,
   input logic [N_REQ-1:0][PORT_W-1:0]  req_port,
   input logic [N_REQ-1:0]              gnt_valid,
   input logic [N_REQ-1:0][VC_W-1:0]    gnt_vc
);

   logic [N_REQ-1:0][PORT_W-1:0]     port_q;
   logic                             dup_pair;
   logic [NUM_PORTS-1:0][N_REQ-1:0]  to_port;

   always_ff @(posedge clk) begin
      port_q <= req_port;
   end

   always_comb begin
      dup_pair = 1'b0;
      for (int a = 0; a < N_REQ; a++) begin
         for (int b = a + 1; b < N_REQ; b++) begin
            if (gnt_valid[a] && gnt_valid[b] &&
                port_q[a] == port_q[b] && gnt_vc[a] == gnt_vc[b]) begin
               dup_pair = 1'b1;
            end
         end
      end
   end

   // R5
   unique_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_pair);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      for (genvar r = 0; r < N_REQ; r++) begin : g_req
         assign to_port[p][r] = gnt_valid[r] && (port_q[r] == PORT_W'(p));
      end
      // R3
      one_per_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(to_port[p]) <= 1);
   end

   for (genvar r = 0; r < N_REQ; r++) begin : g_each
      // R2
      grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_valid[r] |-> $past(req_valid[r] && (int'(req_port[r]) < NUM_PORTS)));
      // R8
      no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_valid[r] |=> !gnt_valid[r]);
   end

endmodule

bind ovc_alloc ovc_alloc_chk #(
   .NUM_PORTS (NUM_PORTS),
   .IN_VCS    (IN_VCS),
   .OUT_VCS   (OUT_VCS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_port  (req_port),
   .gnt_valid (gnt_valid),
   .gnt_vc    (gnt_vc)
);

// File: tb/tb_ovc_alloc.sv
`timescale 1ns/1ps
module tb_ovc_alloc;

   localparam int NP = 5;
   localparam int IV = 4;
   localparam int OV = 4;
   localparam int NR = NP * IV;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NR-1:0]           req_valid = '0;
   logic [NR-1:0][2:0]      req_port = '0;
   logic [NP-1:0]           rel_valid = '0;
   logic [NP-1:0][1:0]      rel_vc = '0;
   logic [NR-1:0]           gnt_valid;
   logic [NR-1:0][1:0]      gnt_vc;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ovc_alloc #(.NUM_PORTS(NP), .IN_VCS(IV), .OUT_VCS(OV)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_port  (req_port),
      .rel_valid (rel_valid),
      .rel_vc    (rel_vc),
      .gnt_valid (gnt_valid),
      .gnt_vc    (gnt_vc)
   );

   // Behavioural reference model
   int m_busy [NP][OV];
   int m_ptr  [NP];
   bit exp_v  [NR];
   int exp_vc [NR];
   bit nv     [NR];
   int nvc    [NR];
   bit relm   [NP][OV];
   int m_fv, m_r;
   bit m_taken;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_ptr[p] = 0;
            for (int v = 0; v < OV; v++) m_busy[p][v] = 0;
         end
         for (int r = 0; r < NR; r++) begin
            exp_v[r] = 1'b0;
            exp_vc[r] = 0;
         end
      end else begin
         for (int r = 0; r < NR; r++) begin
            nv[r] = 1'b0;
            nvc[r] = 0;
         end
         for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < OV; v++)
               relm[p][v] = rel_valid[p] && int'(rel_vc[p]) == v && m_busy[p][v] == 1;
         end
         for (int p = 0; p < NP; p++) begin
            m_fv = -1;
            for (int v = OV - 1; v >= 0; v--) if (m_busy[p][v] == 0) m_fv = v;
            m_taken = 1'b0;
            if (m_fv >= 0) begin
               for (int k = 0; k < NR; k++) begin
                  m_r = (m_ptr[p] + k) % NR;
                  if (!m_taken && req_valid[m_r] && int'(req_port[m_r]) == p && !exp_v[m_r]) begin
                     m_taken = 1'b1;
                     nv[m_r] = 1'b1;
                     nvc[m_r] = m_fv;
                     m_busy[p][m_fv] = 1;
                     m_ptr[p] = (m_r + 1) % NR;
                  end
               end
            end
         end
         for (int p = 0; p < NP; p++)
            for (int v = 0; v < OV; v++) if (relm[p][v]) m_busy[p][v] = 0;
         for (int r = 0; r < NR; r++) begin
            exp_v[r] = nv[r];
            exp_vc[r] = nvc[r];
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One clock, then compare every output against the model
   task automatic cycle();
      bit bad;
      @(posedge clk);
      @(negedge clk);
      checks++;
      bad = 1'b0;
      for (int r = 0; r < NR; r++) begin
         if (!bad && (gnt_valid[r] != exp_v[r] ||
                      (exp_v[r] && int'(gnt_vc[r]) != exp_vc[r]))) begin
            bad = 1'b1;
            fails++;
            $display("FAIL R4 model compare requester %0d: actual valid %0b vc %0d expected valid %0b vc %0d",
                     r, gnt_valid[r], gnt_vc[r], exp_v[r], exp_vc[r]);
         end
      end
   endtask

   task automatic ask(input int r, input int p);
      req_valid[r] = 1'b1;
      req_port[r]  = 3'(p);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   int st [NR];
   int ap [NR];
   int av [NR];
   int cnt[NR];

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 no grant after reset", int'(gnt_valid), 0);

      // Single request: lowest channel, one cycle later
      ask(7, 2);
      cycle();
      chk("R2 grant next cycle", int'(gnt_valid), 1 << 7);
      chk("R1 first channel is 0", int'(gnt_vc[7]), 0);
      req_valid[7] = 1'b0;
      cycle();
      chk("R2 grant is one pulse", int'(gnt_valid), 0);

      // Three on port 1, pointer at 0
      ask(3, 1); ask(9, 1); ask(15, 1);
      cycle();
      chk("R4 first winner", int'(gnt_valid), 1 << 3);
      chk("R3 lowest free channel", int'(gnt_vc[3]), 0);
      req_valid[3] = 1'b0;
      cycle();
      chk("R7 retry wins", int'(gnt_valid), 1 << 9);
      chk("R3 next channel", int'(gnt_vc[9]), 1);
      req_valid[9] = 1'b0;
      cycle();
      chk("R4 third winner", int'(gnt_valid), 1 << 15);
      chk("R3 third channel", int'(gnt_vc[15]), 2);
      req_valid[15] = 1'b0;

      // Pointer at 16 wraps past 2
      ask(2, 1); ask(16, 1);
      cycle();
      chk("R4 wrap order", int'(gnt_valid), 1 << 16);
      chk("R3 last channel", int'(gnt_vc[16]), 3);
      req_valid[16] = 1'b0;
      cycle();
      chk("R5 full port grants nothing", int'(gnt_valid), 0);
      rel_valid[1] = 1'b1; rel_vc[1] = 2'd1;
      cycle();
      chk("R6 release not usable same cycle", int'(gnt_valid), 0);
      rel_valid[1] = 1'b0;
      cycle();
      chk("R6 freed channel granted", int'(gnt_valid), 1 << 2);
      chk("R6 freed channel index", int'(gnt_vc[2]), 1);
      req_valid[2] = 1'b0;

      // Request held past its grant
      ask(5, 3);
      cycle();
      chk("R8 grant", int'(gnt_valid), 1 << 5);
      cycle();
      chk("R8 masked while grant visible", int'(gnt_valid), 0);
      req_valid[5] = 1'b0;
      ask(6, 3);
      cycle();
      chk("R8 no extra channel taken", int'(gnt_valid), 1 << 6);
      chk("R8 next channel is 1", int'(gnt_vc[6]), 1);
      req_valid[6] = 1'b0;

      // Port number out of range
      ask(11, 7);
      cycle();
      chk("R9 bad port ignored", int'(gnt_valid), 0);
      cycle();
      chk("R9 bad port still ignored", int'(gnt_valid), 0);
      req_valid[11] = 1'b0;
      ask(12, 4);
      cycle();
      chk("R9 port 4 untouched", int'(gnt_vc[12]), 0);
      req_valid[12] = 1'b0;

      // Several ports in one cycle
      ask(8, 2); ask(10, 3); ask(13, 4);
      cycle();
      chk("R3 ports grant in parallel", int'(gnt_valid), (1 << 8) | (1 << 10) | (1 << 13));
      chk("R3 port 2 channel", int'(gnt_vc[8]), 1);
      chk("R3 port 3 channel", int'(gnt_vc[10]), 2);
      chk("R3 port 4 channel", int'(gnt_vc[13]), 1);
      req_valid[8] = 1'b0; req_valid[10] = 1'b0; req_valid[13] = 1'b0;

      // Release of a free channel has no effect
      rel_valid[0] = 1'b1; rel_vc[0] = 2'd2;
      cycle();
      rel_valid[0] = 1'b0;
      ask(0, 0); ask(1, 0); ask(4, 0);
      cycle();
      req_valid[0] = 1'b0;
      cycle();
      req_valid[1] = 1'b0;
      cycle();
      chk("R6 free release no effect", int'(gnt_valid), 1 << 4);
      chk("R6 channel 2 still free", int'(gnt_vc[4]), 2);
      req_valid[4] = 1'b0;

      // Clear every channel
      for (int v = 0; v < OV; v++) begin
         rel_valid = '1;
         for (int p = 0; p < NP; p++) rel_vc[p] = 2'(v);
         cycle();
      end
      rel_valid = '0;

      // Random traffic against the model
      for (int r = 0; r < NR; r++) begin
         st[r] = 0; ap[r] = 0; av[r] = 0; cnt[r] = 0;
      end
      for (int c = 0; c < 3000; c++) begin
         rel_valid = '0;
         for (int r = 0; r < NR; r++) begin
            if (st[r] == 1 && gnt_valid[r]) begin
               st[r] = 2;
               av[r] = int'(gnt_vc[r]);
               cnt[r] = 1 + int'($urandom % 5);
            end else if (st[r] == 2) begin
               cnt[r]--;
               if (cnt[r] <= 0 && !rel_valid[ap[r]]) begin
                  rel_valid[ap[r]] = 1'b1;
                  rel_vc[ap[r]] = 2'(av[r]);
                  st[r] = 0;
               end
            end else if (st[r] == 0 && ($urandom % 3) == 0) begin
               st[r] = 1;
               ap[r] = int'($urandom % NP);
            end
            req_valid[r] = (st[r] == 1);
            req_port[r] = 3'(ap[r]);
         end
         cycle();
      end

      summary();
      $finish;
   end

endmodule